// File: doc/BRIEF.md
# Per-Source Interrupt Mask Controller

This block merges interrupt events from one global source and up to fifteen channel sources into one interrupt line to the host. Each source has a free-running event counter, an acknowledge register and a mask bit. A source is pending while its counter differs from the value the host last acknowledged. The interrupt line is raised while any pending source is also unmasked.

The host controls the masks through one 32-bit command word. Each source owns a 2-bit field in that word, so a single write can mask some sources, unmask others and leave the rest as they are. The host acknowledges a source by writing back the counter value it has processed. The low byte of each counter also serves as the head index of that source's message ring.

Source 0 is the global source. Source s, for s from 1 to the channel count, is channel s-1.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After reset, every source is masked, every counter and acknowledge value is zero, and `irq_o` is low.
- R2: A source's counter adds one on each clock cycle in which its event input is high, and wraps modulo 2^CNT_W. The counter for source s reads at address 0x10+s, zero-extended. Its low 8 bits are the ring head index.
- R3: A write to address 0x00 gives each source s the command in `reg_wdata[2s+1:2s]`. The values are: 00 no action, 01 unmask, 10 mask, 11 no action. A read of address 0x00 returns the mask bits, with bit s set when source s is masked.
- R4: Writing 0x55555555 to address 0x00 unmasks every source in one access.
- R5: `irq_o` is registered. In the cycle after any source is both pending (counter not equal to acknowledge value) and unmasked, it is high. Otherwise it is low in the following cycle.
- R6: A write to address 0x10+s stores `reg_wdata` as the acknowledge value of source s, which clears its pending state when the value equals the counter. The stored value reads back at address 0x20+s.
- R7: An event in the same cycle as an acknowledge write still increments the counter. The source therefore stays pending after acknowledging the old count.
- R8: Reads of unmapped addresses (including 0x01 to 0x0F and unused source slots) return zero. Writes to any address other than 0x00 and 0x10+s change no state.
- R9: A masked source keeps its pending state without raising `irq_o`. Unmasking it later raises `irq_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | NUM_CH+1 | Event pulse per source, bit 0 global |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq_o | output | 1 | Registered interrupt line to the host |

## Verification
The hardest situation to reach from the ports is an event that lands in exactly the cycle of an acknowledge write for the same source. The bench holds the event input high across the single write cycle and then reads back the counter and the interrupt line. Counter wrap is reached by building the bench with an 8-bit counter and streaming more than 256 events, so that the count comes back to the acknowledged value and the source goes quiet without any new acknowledge.

// File: rtl/irqm_pkg.sv
// Package: shared address map and command encoding for the interrupt mask controller.
// Assumes at most 16 sources, so a source index fits in the low 4 address bits.
package irqm_pkg;
    localparam int ADDR_W   = 6;
    localparam int MAX_SRC  = 16;
    localparam int DATA_W   = 32;

    typedef logic [ADDR_W-1:0] addr_t;

    // Region bases; the source index occupies addr[3:0]
    localparam addr_t MASK_ADDR = 6'h00;
    localparam addr_t CNT_BASE  = 6'h10;
    localparam addr_t ACK_BASE  = 6'h20;

    // 2-bit per-source mask command
    typedef enum logic [1:0] {
        CMD_KEEP0  = 2'b00,
        CMD_UNMASK = 2'b01,
        CMD_MASK   = 2'b10,
        CMD_KEEP1  = 2'b11
    } mask_cmd_e;
endpackage

// File: rtl/irqm_src.sv
// Module: state of one interrupt source: event counter, acknowledged value and mask bit.
// Assumes the command field is only sampled when cmd_we is high; the reset state is masked.
module irqm_src #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic             ack_we,
    input  logic [CNT_W-1:0] ack_val,
    input  logic             cmd_we,
    input  logic [1:0]       cmd,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] ack,
    output logic             masked,
    output logic             active
);
    import irqm_pkg::*;

    // Event counter: one step per event cycle, wraps naturally
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else if (evt) cnt <= cnt + CNT_W'(1);
    end

    // Acknowledged count, loaded by the host
    always_ff @(posedge clk) begin
        if (!rst_n) ack <= '0;
        else if (ack_we) ack <= ack_val;
    end

    // Mask bit, driven by the 2-bit command
    always_ff @(posedge clk) begin
        if (!rst_n) masked <= 1'b1;
        else if (cmd_we) begin
            case (mask_cmd_e'(cmd))
                CMD_UNMASK: masked <= 1'b0;
                CMD_MASK:   masked <= 1'b1;
                default:    masked <= masked;
            endcase
        end
    end

    // Pending and not masked
    always_comb active = (cnt != ack) && !masked;
endmodule

// File: rtl/irqm_rd_mux.sv
// Module: read-data selection over mask, counter and acknowledge regions.
// Assumes NUM_SRC <= 16; unmapped addresses and empty slots read as zero.
module irqm_rd_mux #(
    parameter int NUM_SRC = 16,
    parameter int CNT_W   = 32
) (
    input  irqm_pkg::addr_t                 addr,
    input  logic [NUM_SRC-1:0][CNT_W-1:0]  cnt_all,
    input  logic [NUM_SRC-1:0][CNT_W-1:0]  ack_all,
    input  logic [NUM_SRC-1:0]             mask_vec,
    output logic [irqm_pkg::DATA_W-1:0]    rdata
);
    import irqm_pkg::*;

    // Region decode, then slot select
    always_comb begin
        rdata = '0;
        if (addr == MASK_ADDR) begin
            rdata[NUM_SRC-1:0] = mask_vec;
        end else begin
            for (int s = 0; s < NUM_SRC; s++) begin
                if (addr == CNT_BASE + addr_t'(s)) rdata[CNT_W-1:0] = cnt_all[s];
                if (addr == ACK_BASE + addr_t'(s)) rdata[CNT_W-1:0] = ack_all[s];
            end
        end
    end
endmodule

// File: rtl/irq_mask_ctrl.sv
// Module: top of the per-source interrupt mask controller.
// Holds one irqm_src per source, decodes register writes and registers the merged line.
// Assumes NUM_CH <= 15 and CNT_W <= 32.
module irq_mask_ctrl #(
    parameter int NUM_CH = 15,
    parameter int CNT_W  = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [NUM_CH:0] evt_i,
    input  logic        reg_wr,
    input  logic [5:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq_o
);
    import irqm_pkg::*;

    localparam int NUM_SRC = NUM_CH + 1;

    logic [NUM_SRC-1:0][CNT_W-1:0] cnt_all;
    logic [NUM_SRC-1:0][CNT_W-1:0] ack_all;
    logic [NUM_SRC-1:0]            mask_vec;
    logic [NUM_SRC-1:0]            act_vec;
    logic [NUM_SRC-1:0]            ack_we;
    logic                          mask_we;

    // Mask command write strobe
    always_comb mask_we = reg_wr && (reg_addr == MASK_ADDR);

    // Per-source slots with their own ack strobe and command field
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        assign ack_we[s] = reg_wr && (reg_addr == CNT_BASE + addr_t'(s));

        irqm_src #(.CNT_W(CNT_W)) u_src (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt     (evt_i[s]),
            .ack_we  (ack_we[s]),
            .ack_val (reg_wdata[CNT_W-1:0]),
            .cmd_we  (mask_we),
            .cmd     (reg_wdata[2*s+1:2*s]),
            .cnt     (cnt_all[s]),
            .ack     (ack_all[s]),
            .masked  (mask_vec[s]),
            .active  (act_vec[s])
        );
    end

    irqm_rd_mux #(.NUM_SRC(NUM_SRC), .CNT_W(CNT_W)) u_rd (
        .addr     (reg_addr),
        .cnt_all  (cnt_all),
        .ack_all  (ack_all),
        .mask_vec (mask_vec),
        .rdata    (reg_rdata)
    );

    // Registered interrupt line
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= |act_vec;
    end
endmodule

// File: rtl/irqm_checker.sv
// Module: assertion checker bound into irq_mask_ctrl.
// Observes ports and per-source slot outputs; has no outputs of its own.
module irqm_checker #(
    parameter int NUM_SRC = 16,
    parameter int CNT_W   = 32
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [NUM_SRC-1:0]            evt_i,
    input logic                          reg_wr,
    input logic [5:0]                    reg_addr,
    input logic [31:0]                   reg_wdata,
    input logic                          irq_o,
    input logic [NUM_SRC-1:0][CNT_W-1:0] cnt_all,
    input logic [NUM_SRC-1:0][CNT_W-1:0] ack_all,
    input logic [NUM_SRC-1:0]            mask_vec,
    input logic [NUM_SRC-1:0]            act_vec
);
    // Line low while in reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !irq_o);

    // Line follows merged activity one cycle later
    assert_irq_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|act_vec) |=> irq_o);
    assert_irq_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(|act_vec) |=> !irq_o);

    // Mask commands for the global source
    assert_mask_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 6'h00 && reg_wdata[1:0] == 2'b10) |=> mask_vec[0]);
    assert_mask_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 6'h00 && reg_wdata[1:0] == 2'b01) |=> !mask_vec[0]);
    assert_mask_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == 6'h00) |=> $stable(mask_vec));

    // Ack load for the global source
    assert_ack_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 6'h10) |=> ack_all[0] == $past(reg_wdata[CNT_W-1:0]));

    // Event during acknowledge of the current count leaves the source pending
    assert_evt_on_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 6'h10 && evt_i[0] && reg_wdata[CNT_W-1:0] == cnt_all[0])
        |=> cnt_all[0] != ack_all[0]);

    // Counter steps exactly on events
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_cnt
        assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[s] |=> cnt_all[s] == $past(cnt_all[s]) + CNT_W'(1));
        assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !evt_i[s] |=> $stable(cnt_all[s]));
    end
endmodule

bind irq_mask_ctrl irqm_checker #(.NUM_SRC(NUM_SRC), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt_i),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .irq_o     (irq_o),
    .cnt_all   (cnt_all),
    .ack_all   (ack_all),
    .mask_vec  (mask_vec),
    .act_vec   (act_vec)
);

// File: tb/irq_mask_ctrl_test.sv
`timescale 1ns/1ps
// Bench: mask command table walk, then directed tests for pending, ack, wrap and address map.
module irq_mask_ctrl_test;
    localparam int NUM_CH = 15;
    localparam int CNT_W  = 8;
    localparam int NSRC   = NUM_CH + 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] evt_i = '0;
    logic            reg_wr = 1'b0;
    logic [5:0]      reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic            irq_o;

    int n_chk = 0;
    int n_fail = 0;

    irq_mask_ctrl #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    always #10 clk = ~clk;

    // {command word, expected mask readback}
    localparam logic [47:0] MASK_TBL [10] = '{
        {32'h0000_0000, 16'hFFFF},
        {32'h0000_0001, 16'hFFFE},
        {32'hFFFF_FFFF, 16'hFFFE},
        {32'h0000_0004, 16'hFFFC},
        {32'h4000_0000, 16'h7FFC},
        {32'h0000_0006, 16'h7FFD},
        {32'h5555_5555, 16'h0000},
        {32'hAAAA_AAAA, 16'hFFFF},
        {32'h9999_9999, 16'hAAAA},
        {32'h0000_00F0, 16'hAAAA}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input int src, input int n);
        evt_i[src] = 1'b1;
        repeat (n) @(negedge clk);
        evt_i = '0;
    endtask

    initial begin
        #4000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq", {31'd0, irq_o}, 0);
        rd(6'h00, d); chk("R1 mask", d, 32'hFFFF);
        rd(6'h10, d); chk("R1 cnt0", d, 0);
        rd(6'h1F, d); chk("R1 cnt15", d, 0);
        rd(6'h20, d); chk("R1 ack0", d, 0);

        // R3/R4 mask command table
        for (int i = 0; i < 10; i++) begin
            wr(6'h00, MASK_TBL[i][47:16]);
            rd(6'h00, d);
            chk("R3/R4 mask table", d, {16'd0, MASK_TBL[i][15:0]});
        end
        chk("R3 no irq without events", {31'd0, irq_o}, 0);

        // R9 masked source counts but stays quiet; R2 count readback
        pulse(3, 5);
        @(negedge clk);
        chk("R9 masked quiet", {31'd0, irq_o}, 0);
        rd(6'h13, d); chk("R2 cnt3", d, 5);
        rd(6'h12, d); chk("R2 cnt2 untouched", d, 0);
        wr(6'h00, 32'h0000_0040);
        @(negedge clk);
        chk("R9 unmask raises", {31'd0, irq_o}, 1);

        // R6 acknowledge clears
        wr(6'h13, 5);
        chk("R5 registered hold", {31'd0, irq_o}, 1);
        @(negedge clk);
        chk("R6 ack clears", {31'd0, irq_o}, 0);
        rd(6'h23, d); chk("R6 ack readback", d, 5);

        // R7 event in ack cycle
        evt_i[3] = 1'b1;
        wr(6'h13, 5);
        evt_i = '0;
        @(negedge clk);
        chk("R7 still pending", {31'd0, irq_o}, 1);
        rd(6'h13, d); chk("R7 cnt3", d, 6);
        wr(6'h13, 6);
        @(negedge clk);
        chk("R7 cleared", {31'd0, irq_o}, 0);

        // R5 one-cycle registration on global source
        pulse(0, 1);
        chk("R5 not yet", {31'd0, irq_o}, 0);
        @(negedge clk);
        chk("R5 raised", {31'd0, irq_o}, 1);
        rd(6'h10, d); chk("R2 head index", d, 1);
        wr(6'h10, 1);
        @(negedge clk);
        chk("R5 fall", {31'd0, irq_o}, 0);

        // R2 wrap
        pulse(0, 254);
        @(negedge clk);
        rd(6'h10, d); chk("R2 cnt 255", d, 32'hFF);
        chk("R2 pending at 255", {31'd0, irq_o}, 1);
        pulse(0, 2);
        @(negedge clk);
        rd(6'h10, d); chk("R2 wrap value", d, 1);
        chk("R2 wrap matches ack", {31'd0, irq_o}, 0);

        // R8 unmapped accesses
        rd(6'h3F, d); chk("R8 unmapped read", d, 0);
        rd(6'h05, d); chk("R8 gap read", d, 0);
        wr(6'h3F, 32'h5555_5555);
        rd(6'h00, d); chk("R8 mask untouched", d, 32'hAAA2);
        wr(6'h23, 0);
        rd(6'h23, d); chk("R8 ack region write ignored", d, 6);
        rd(6'h13, d); chk("R8 cnt3 untouched", d, 6);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule